// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write PHY management registers over the two-wire MDC/MDIO link. The host reaches it through a small 32-bit register port with two locations. The command register at offset 0x48 holds the operation, the PHY address, the register address and the MDC divider code. The data register at offset 0x4C carries the word to send, or the word that was read back. The command register also holds a busy bit at bit 0. Writing it as 1 starts a frame. The hardware keeps it at 1 until the frame is over, so the host polls the same bit it used to start the frame.

The block divides the system clock to make MDC. It shifts out a clause-22 management frame of 64 bit periods:

- 32 preamble ones;
- start pattern 01;
- opcode 01 for a write or 10 for a read;
- five PHY address bits;
- the low five bits of the register field;
- two turnaround bits;
- sixteen data bits.

Every field is sent MSB first. On a read, the block stops driving MDIO for the turnaround and data periods. It takes each data bit from MDIO on the rising edge of MDC.

The controller is a state machine:

- **IDLE** goes to **PREAMBLE** when a start is accepted.
- **PREAMBLE** goes to **HEADER** after 32 bit periods.
- **HEADER** goes to **TURNAROUND** after 14 periods.
- **TURNAROUND** goes to **DATA** after 2 periods.
- **DATA** goes to **DONE** after 16 periods.
- **DONE** returns to **IDLE** after one clock. In that cycle a read result is written into the data register.

All bit-period transitions happen on the system clock edge where MDC falls.

Top module: `mdio_master`

## Requirements
- R1: During and right after reset, MDC is low, MDIO output-enable is low, busy is 0, and both registers read as zero.
- R2: The command register reads back as follows: divider code in bits 22:20, PHY address in bits 16:12, a 7-bit register field in bits 10:4, write select in bit 1 (1 = write, 0 = read), busy in bit 0. All other bits read as zero. An idle write with bit 0 clear updates the fields and starts nothing. An idle write with bit 0 set starts a frame, and busy reads 1 from the next cycle.
- R3: Divider codes 0, 1, 2, 3, 4 and 5 give MDC periods of 42, 62, 16, 26, 102 and 124 system clocks. Busy stays high for exactly 64 × period + 1 clocks.
- R4: Divider codes 6 and 7 behave as a period of 124 clocks.
- R5: A write frame is 32 ones, then 01, 01, the PHY address, the low 5 register bits, 10, and the data register value, all MSB first and all driven. MDIO changes only on the clock edge where MDC goes low.
- R6: A read frame sends opcode 10. Output-enable is low for the 2 turnaround and 16 data periods. The 16 bits sampled at MDC rising edges, MSB first, are in bits 15:0 of the data register when busy clears.
- R7: Command-register writes while busy is 1 are ignored. Neither the register fields nor the frame in flight change.
- R8: If a host write to the data register arrives in the same cycle a read result is stored, the read result is kept.
- R9: Whenever busy is 0, MDC is low and MDIO output-enable is low.
- R10: The data register holds a host-written value in bits 15:0 and reads 0 in bits 31:16. A write frame does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for csr_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data sampled value |

## Verification
Two functions can land in the same cycle: storing a finished read result in the data register, and a host write to that same register. The bench counts clocks from the accepted start. It places a host data write exactly on the DONE cycle of a read, 64 × period + 1 edges after the start edge. It then checks that the PHY-supplied word, not the host word, is in the data register. A second collision targets the command register: a write that arrives mid-frame must leave the read-back fields, the frame length and every transmitted bit unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Frame geometry, in MDC bit periods
    localparam int PRE_LEN   = 32;
    localparam int PHY_W     = 5;
    localparam int REGA_W    = 5;
    localparam int WORD_W    = 16;
    localparam int HDR_LEN   = 2 + 2 + PHY_W + REGA_W;
    localparam int TA_LEN    = 2;
    localparam int SHIFT_W   = HDR_LEN + TA_LEN + WORD_W;
    localparam int BITCNT_W  = $clog2(PRE_LEN + 1);
    localparam int DIV_W     = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } mdio_state_e;

    // Divider code to MDC period; reserved codes fall back to the slowest ratio
    function automatic logic [DIV_W-1:0] div_ratio(input logic [2:0] code);
        logic [DIV_W-1:0] r;
        unique case (code)
            3'd0:    r = 7'd42;
            3'd1:    r = 7'd62;
            3'd2:    r = 7'd16;
            3'd3:    r = 7'd26;
            3'd4:    r = 7'd102;
            default: r = 7'd124;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
    import mdio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] code,
    output logic       mdc,
    output logic       rise_tick,
    output logic       fall_tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] half;

    always_comb begin
        ratio     = div_ratio(code);
        half      = ratio >> 1;
        rise_tick = run && (cnt == half - 7'd1);
        fall_tick = run && (cnt == ratio - 7'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_tick) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + 7'd1;
            if (rise_tick) begin
                mdc <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdio_fsm.sv
module mdio_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [PHY_W-1:0]  start_phy,
    input  logic [REGA_W-1:0] start_reg,
    input  logic [WORD_W-1:0] start_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output mdio_state_e       state,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [WORD_W-1:0] rx_data
);

    mdio_state_e         nxt;
    logic                wr_l;
    logic [SHIFT_W-1:0]  tx_shift;
    logic [WORD_W-1:0]   rx_shift;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BITCNT_W-1:0] seg_len;
    logic                seg_last;
    logic                in_frame;
    logic                shifting;

    // Length of the current segment in bit periods
    always_comb begin
        unique case (state)
            ST_PRE:  seg_len = BITCNT_W'(PRE_LEN);
            ST_HDR:  seg_len = BITCNT_W'(HDR_LEN);
            ST_TURN: seg_len = BITCNT_W'(TA_LEN);
            ST_DATA: seg_len = BITCNT_W'(WORD_W);
            default: seg_len = BITCNT_W'(1);
        endcase
        seg_last = (bit_cnt == seg_len - BITCNT_W'(1));
        in_frame = (state != ST_IDLE) && (state != ST_DONE);
        shifting = (state == ST_HDR) || (state == ST_TURN) || (state == ST_DATA);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)                 nxt = ST_PRE;
            ST_PRE:  if (fall_tick && seg_last) nxt = ST_HDR;
            ST_HDR:  if (fall_tick && seg_last) nxt = ST_TURN;
            ST_TURN: if (fall_tick && seg_last) nxt = ST_DATA;
            ST_DATA: if (fall_tick && seg_last) nxt = ST_DONE;
            ST_DONE:                            nxt = ST_IDLE;
            default:                            nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Datapath: bit counter, transmit and receive shifters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_l     <= 1'b0;
            tx_shift <= '0;
            rx_shift <= '0;
            bit_cnt  <= '0;
        end else if (state == ST_IDLE && start) begin
            wr_l     <= start_wr;
            tx_shift <= {2'b01, (start_wr ? 2'b01 : 2'b10), start_phy, start_reg,
                         2'b10, start_data};
            bit_cnt  <= '0;
        end else begin
            if (fall_tick && in_frame) begin
                bit_cnt <= seg_last ? '0 : bit_cnt + BITCNT_W'(1);
                if (shifting) begin
                    tx_shift <= {tx_shift[SHIFT_W-2:0], 1'b0};
                end
            end
            if (rise_tick && state == ST_DATA) begin
                rx_shift <= {rx_shift[WORD_W-2:0], mdio_i};
            end
        end
    end

    // Output decode from the registered state
    always_comb begin
        unique case (state)
            ST_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HDR: begin
                mdio_o  = tx_shift[SHIFT_W-1];
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                mdio_o  = tx_shift[SHIFT_W-1];
                mdio_oe = wr_l;
            end
            default: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
        endcase
        rx_data = rx_shift;
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_OFS  = 'h48,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    mdio_state_e       state;
    logic              busy;
    logic              run;
    logic              cmd_hit;
    logic              data_hit;
    logic              start;
    logic              wr_q;
    logic [PHY_W-1:0]  phy_q;
    logic [6:0]        reg_q;
    logic [2:0]        div_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] rx_data;
    logic              rise_tick;
    logic              fall_tick;
    logic              unused_bits;

    assign busy        = (state != ST_IDLE);
    assign run         = busy && (state != ST_DONE);
    assign cmd_hit     = csr_we && (csr_addr == CMD_OFS);
    assign data_hit    = csr_we && (csr_addr == DATA_OFS);
    assign start       = cmd_hit && !busy && csr_wdata[0];
    assign unused_bits = ^{csr_wdata[31:23], csr_wdata[19:17], csr_wdata[11],
                           csr_wdata[3:2]};

    // Command fields: writable only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            phy_q <= '0;
            reg_q <= '0;
            div_q <= '0;
        end else if (cmd_hit && !busy) begin
            wr_q  <= csr_wdata[1];
            phy_q <= csr_wdata[16:12];
            reg_q <= csr_wdata[10:4];
            div_q <= csr_wdata[22:20];
        end
    end

    // Data register: a finished read has priority over a host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state == ST_DONE && !wr_q) begin
            data_q <= rx_data;
        end else if (data_hit) begin
            data_q <= csr_wdata[WORD_W-1:0];
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (csr_addr == CMD_OFS) begin
            csr_rdata[22:20] = div_q;
            csr_rdata[16:12] = phy_q;
            csr_rdata[10:4]  = reg_q;
            csr_rdata[1]     = wr_q;
            csr_rdata[0]     = busy;
        end else if (csr_addr == DATA_OFS) begin
            csr_rdata[WORD_W-1:0] = data_q;
        end
    end

    mdio_clkdiv u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .code      (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_wr   (csr_wdata[1]),
        .start_phy  (csr_wdata[16:12]),
        .start_reg  (csr_wdata[8:4]),
        .start_data (data_q),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .state      (state),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rx_data    (rx_data)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input mdio_state_e state,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        wr_q,
    input logic [4:0]  phy_q,
    input logic [2:0]  div_q,
    input logic        cmd_hit
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));  // R9

    AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_hit) |=> ($stable(phy_q) && $stable(div_q) && $stable(wr_q)));  // R7

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TURN || state == ST_DATA) && !wr_q) |-> !mdio_oe);  // R6

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);  // R5

    AST_HEAD_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE || state == ST_HDR) |-> mdio_oe);  // R5

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .wr_q    (wr_q),
    .phy_q   (phy_q),
    .div_q   (div_q),
    .cmd_hit (cmd_hit)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CMD_A  = 8'h48;
    localparam logic [7:0] DATA_A = 8'h4C;
    localparam logic [31:0] POKE  = {9'd0, 3'd5, 3'd0, 5'h1C, 1'b0, 7'h7F, 2'b00, 1'b0, 1'b1};

    // {write, divider code, phy, register field, data}
    localparam logic [31:0] VEC [8] = '{
        {1'b1, 3'd2, 5'h01, 7'h00, 16'hA5C3},
        {1'b0, 3'd3, 5'h1F, 7'h1F, 16'h1234},
        {1'b1, 3'd0, 5'h12, 7'h6A, 16'hFFFF},
        {1'b0, 3'd1, 5'h00, 7'h05, 16'h8001},
        {1'b1, 3'd4, 5'h0A, 7'h15, 16'h0000},
        {1'b0, 3'd5, 5'h15, 7'h0A, 16'h5A5A},
        {1'b1, 3'd6, 5'h07, 7'h11, 16'h3C3C},
        {1'b0, 3'd7, 5'h19, 7'h02, 16'hC3A5}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_we;
    logic [7:0]  csr_addr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    int          checks = 0;
    int          errs   = 0;
    logic        clr = 1'b0;
    logic        mdc_d;
    int          rise_cnt;
    logic [63:0] fbit;
    logic [63:0] foe;
    logic [15:0] phy_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY model: records each bit at MDC rise, supplies read data
    always @(posedge clk) begin
        mdc_d <= mdc;
        if (clr) begin
            rise_cnt <= 0;
            fbit     <= '0;
            foe      <= '0;
        end else if (mdc && !mdc_d) begin
            if (rise_cnt < 64) begin
                fbit[63-rise_cnt] <= mdio_o;
                foe[63-rise_cnt]  <= mdio_oe;
            end
            rise_cnt <= rise_cnt + 1;
        end
    end

    always_comb begin
        if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_val[63-rise_cnt];
        else                                 mdio_i = 1'b1;
    end

    function automatic int exp_ratio(input logic [2:0] c);
        case (c)
            3'd0: return 42;
            3'd1: return 62;
            3'd2: return 16;
            3'd3: return 26;
            3'd4: return 102;
            default: return 124;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [7:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    // mode 0: plain, 1: command poke mid-frame, 2: data write on completion cycle
    task automatic run_txn(input logic wr, input logic [2:0] dv, input logic [4:0] ph,
                           input logic [6:0] rg, input logic [15:0] dat, input int mode);
        int n;
        int ratio;
        logic [31:0] cmd;
        logic [31:0] rd;
        logic [63:0] ef;
        logic [63:0] eo;
        ratio = exp_ratio(dv);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        if (wr) csr_write(DATA_A, {16'h0, dat});
        else    phy_val = dat;
        cmd = {9'd0, dv, 3'd0, ph, 1'b0, rg, 2'b00, wr, 1'b1};
        csr_write(CMD_A, cmd);
        csr_read(CMD_A, rd);
        chk("R2 readback while busy", rd, cmd);
        n = 0;
        while (rd[0]) begin
            n++;
            if (mode == 1 && n == 100) begin
                csr_we = 1'b1; csr_addr = CMD_A; csr_wdata = POKE;
            end
            if (mode == 2 && n == 64*ratio+1) begin
                csr_we = 1'b1; csr_addr = DATA_A; csr_wdata = 32'h0000_1111;
            end
            @(negedge clk);
            csr_we = 1'b0;
            csr_read(CMD_A, rd);
        end
        if (dv >= 3'd6) chk("R4 busy length reserved code", n, 64*ratio+1);
        else            chk("R3 busy length", n, 64*ratio+1);
        chk("R5 rising edges per frame", rise_cnt, 64);
        ef = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), ph, rg[4:0], 2'b10, dat};
        eo = wr ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
        if (wr) begin
            chk("R5 write frame bits", fbit, ef);
            chk("R5 write frame driven", foe, eo);
        end else begin
            chk("R6 read frame header", fbit & eo, ef & eo);
            chk("R6 read release", foe, eo);
        end
        chk(mode == 1 ? "R7 fields after busy write" : "R2 fields after frame",
            rd, {cmd[31:1], 1'b0});
        csr_read(DATA_A, rd);
        if (mode == 2)  chk("R8 read result beats host write", rd, {16'h0, dat});
        else if (wr)    chk("R10 data kept after write", rd, {16'h0, dat});
        else            chk("R6 read result", rd, {16'h0, dat});
        chk("R9 idle mdc/oe", {mdc, mdio_oe}, 2'b00);
        csr_addr = CMD_A;
    endtask

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; csr_we = 1'b0; csr_addr = CMD_A; csr_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset mdc/oe", {mdc, mdio_oe}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        csr_read(CMD_A, rd);
        chk("R1 command after reset", rd, 32'h0);
        csr_read(DATA_A, rd);
        chk("R1 data after reset", rd, 32'h0);
        chk("R1 lines after reset", {mdc, mdio_oe}, 2'b00);

        // Field write with busy bit clear: no frame
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        csr_write(CMD_A, 32'h0051_F0F6);
        repeat (60) @(negedge clk);
        csr_read(CMD_A, rd);
        chk("R2 idle field write", rd, 32'h0051_F0F6 & 32'h0071_F7F2);
        chk("R2 no frame without busy", rise_cnt, 0);
        chk("R9 idle after field write", {mdc, mdio_oe}, 2'b00);

        // Data register upper bits read zero
        csr_write(DATA_A, 32'hDEAD_BEEF);
        csr_read(DATA_A, rd);
        chk("R10 data register width", rd, 32'h0000_BEEF);

        for (int i = 0; i < 8; i++) begin
            run_txn(VEC[i][31], VEC[i][30:28], VEC[i][27:23], VEC[i][22:16], VEC[i][15:0], 0);
        end

        run_txn(1'b1, 3'd2, 5'h03, 7'h04, 16'h0F0F, 1);
        run_txn(1'b0, 3'd2, 5'h02, 7'h03, 16'hC0DE, 2);

        csr_write(DATA_A, 32'h0000_2222);
        csr_read(DATA_A, rd);
        chk("R10 idle data write", rd, 32'h0000_2222);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule